// File: doc/BRIEF.md
# Pulse-Width Single-Wire Bit Receiver

This block listens to a self-clocked single-wire bus and turns it into bytes. The line rests low. Every bit period begins with a rising edge, and the bit value is carried by how long the line then stays high. The line arrives from outside the clock domain. It passes through a flop synchroniser and a glitch filter that counts system clocks. After that, a small timer measures the time since the last qualified rising edge and the length of the low run that came before it.

A message opens with a rising edge after a long enough low idle. The first rise-to-rise interval is a timing-negotiation pulse, and its length becomes the reference period T for the rest of the message. Each later high time H is compared with fixed tenths of T to give a 1, a 0 or a framing error. Bits are packed MSB first into bytes, and each complete byte is strobed out. When two reference periods pass with no rising edge, the message is closed. A partly filled byte is then dropped and reported.

Top module: `pw_bit_receiver`

## Requirements
- R1: The line is synchronised through SYNC_STAGES flops, and a level change is accepted only once the synchronised level has differed from the filtered level for GLITCH_LEN consecutive clocks. A high spike shorter than GLITCH_LEN clocks has no effect on any output. A high pulse of exactly GLITCH_LEN clocks is accepted as an edge.
- R2: A filtered rising edge starts a message only if the filtered line was low for at least IDLE_MIN consecutive clocks just before it. A start raises msg_start for one clock.
- R3: After a start, the clock count from the start edge to the next filtered rising edge becomes the reference period T. No bit is decoded from this negotiation pulse.
- R4: A high time H, in clocks from a rising to a falling filtered edge, with 6T <= 10H <= 8T decodes as a 1 (bounds included).
- R5: A high time with 2T <= 10H <= 4T decodes as a 0 (bounds included).
- R6: Bits are shifted in MSB first (the first data bit lands in byte_data[7]). One clock after the eighth bit, byte_valid is high for one clock and byte_data holds the byte until the next byte completes.
- R7: A high time in neither window raises frame_err for one clock. No byte is strobed for the rest of that message.
- R8: Once a message is past negotiation, msg_stop pulses for one clock when 2T clocks pass since the last rising edge with no new rising edge. The receiver then waits for a new start.
- R9: If the stop comes with 1 to 7 bits pending and no framing error, short_byte pulses together with msg_stop and the partial bits are never strobed.
- R10: If no second rising edge arrives within NEGO_MAX clocks of the start edge, msg_stop pulses (without short_byte) and the receiver returns to idle.
- R11: During and right after reset, all strobes are low and byte_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw bus level, asynchronous |
| byte_data | output | 8 | Last completed byte |
| byte_valid | output | 1 | One-clock strobe for a completed byte |
| msg_start | output | 1 | One-clock strobe for a qualified message start |
| msg_stop | output | 1 | One-clock strobe for end of message |
| frame_err | output | 1 | One-clock strobe for an out-of-window high time |
| short_byte | output | 1 | One-clock strobe, with msg_stop, for a dropped partial byte |

## Verification
The bench drives high times that sit exactly on the edges of the 1 and 0 windows (3T/5, 4T/5, T/5, 2T/5) and just outside them. A design with a strict comparison, or one that rounds the fractions, would decode those bits differently or flag them as errors. It sends a spike one clock shorter than the filter length, and then a pulse of exactly that length. An off-by-one filter would start a message on the spike or miss the real pulse. Rising edges that follow low runs shorter than IDLE_MIN must not open a message. The bench also covers a message that ends mid-byte, one that breaks the window and then carries a full byte, and a negotiation that never completes. Each of these would show up as a stray byte, a missing short_byte or a receiver that never returns to idle.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NEGO  = 2'd1,
    ST_BITS  = 2'd2,
    ST_DRAIN = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_ONE  = 2'd1,
    CLS_BAD  = 2'd2
  } bit_cls_e;

  // window bounds in tenths of the reference period
  localparam int unsigned ONE_LO_T  = 6;
  localparam int unsigned ONE_HI_T  = 8;
  localparam int unsigned ZERO_LO_T = 2;
  localparam int unsigned ZERO_HI_T = 4;

  // classify a measured high time against the reference period
  function automatic bit_cls_e classify_high(input logic [31:0] high_len,
                                             input logic [31:0] period);
    logic [63:0] h10;
    logic [63:0] p64;
    h10 = 64'(high_len) * 64'd10;
    p64 = 64'(period);
    if (h10 >= p64 * 64'(ONE_LO_T) && h10 <= p64 * 64'(ONE_HI_T))
      return CLS_ONE;
    else if (h10 >= p64 * 64'(ZERO_LO_T) && h10 <= p64 * 64'(ZERO_HI_T))
      return CLS_ZERO;
    else
      return CLS_BAD;
  endfunction

  // silence length that closes a message: two reference periods
  function automatic logic [32:0] silence_limit(input logic [31:0] period);
    return {period, 1'b0};
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int HOLD = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic lvl_out,
  output logic rise_p,
  output logic fall_p
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_cnt;
  logic          differs;
  logic          accept;

  assign differs = (lvl_in != lvl_out);
  assign accept  = differs && (run_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      lvl_out <= 1'b0;
      rise_p  <= 1'b0;
      fall_p  <= 1'b0;
    end else begin
      rise_p <= accept && lvl_in;
      fall_p <= accept && !lvl_in;
      if (accept) begin
        lvl_out <= lvl_in;
        run_cnt <= '0;
      end else if (differs) begin
        run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
      end
    end
  end

  // R1: the filtered level only ever moves to the level seen at the input
  p_filter_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_out != $past(lvl_out)) |-> ($past(lvl_in) == lvl_out));

  // R1: an edge strobe always agrees with the new filtered level
  p_edge_matches_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |-> (lvl_out && !$past(lvl_out)));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic             rise_p,
  output logic [CNT_W-1:0] low_run,
  output logic [CNT_W-1:0] since_rise
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run    <= '0;
      since_rise <= '0;
    end else begin
      if (lvl)                low_run <= '0;
      else if (low_run != CMAX) low_run <= low_run + 1'b1;

      if (rise_p)                  since_rise <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (since_rise != CMAX) since_rise <= since_rise + 1'b1;
    end
  end
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
  import pwr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int IDLE_MIN = 16,
  parameter int NEGO_MAX = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_p,
  input  logic             fall_p,
  input  logic [CNT_W-1:0] low_run,
  input  logic [CNT_W-1:0] since_rise,
  output logic [7:0]       byte_data,
  output logic             byte_valid,
  output logic             msg_start,
  output logic             msg_stop,
  output logic             frame_err,
  output logic             short_byte
);
  localparam logic [CNT_W-1:0] IDLE_LIM = CNT_W'(IDLE_MIN);
  localparam logic [CNT_W-1:0] NEGO_LIM = CNT_W'(NEGO_MAX);

  rx_state_e        st;
  logic [CNT_W-1:0] ref_per;
  logic [2:0]       nbits;
  logic [6:0]       shreg;

  // named internal events
  logic     start_ok;
  logic     silence;
  logic     nego_tmo;
  bit_cls_e cls;
  logic     cur_bit;
  logic [32:0] stop_lim;

  always_comb begin
    stop_lim = silence_limit(32'(ref_per));
    start_ok = rise_p && (low_run >= IDLE_LIM);
    silence  = !rise_p && (33'(since_rise) >= stop_lim);
    nego_tmo = !rise_p && (since_rise >= NEGO_LIM);
    cls      = classify_high(32'(since_rise), 32'(ref_per));
    cur_bit  = (cls == CLS_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ref_per    <= '0;
      nbits      <= '0;
      shreg      <= '0;
      byte_data  <= '0;
      byte_valid <= 1'b0;
      msg_start  <= 1'b0;
      msg_stop   <= 1'b0;
      frame_err  <= 1'b0;
      short_byte <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      msg_start  <= 1'b0;
      msg_stop   <= 1'b0;
      frame_err  <= 1'b0;
      short_byte <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_ok) begin
            st        <= ST_NEGO;
            msg_start <= 1'b1;
          end
        end
        ST_NEGO: begin
          if (rise_p) begin
            ref_per <= since_rise;
            nbits   <= '0;
            st      <= ST_BITS;
          end else if (nego_tmo) begin
            msg_stop <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_BITS: begin
          if (silence) begin
            msg_stop   <= 1'b1;
            short_byte <= (nbits != 3'd0);
            st         <= ST_IDLE;
          end else if (fall_p) begin
            if (cls == CLS_BAD) begin
              frame_err <= 1'b1;
              st        <= ST_DRAIN;
            end else begin
              shreg <= {shreg[5:0], cur_bit};
              if (nbits == 3'd7) begin
                byte_data  <= {shreg, cur_bit};
                byte_valid <= 1'b1;
                nbits      <= '0;
              end else begin
                nbits <= nbits + 3'd1;
              end
            end
          end
        end
        ST_DRAIN: begin
          if (silence) begin
            msg_stop <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: a start follows a long enough low run
  p_start_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |-> ($past(low_run) >= IDLE_LIM));

  // R6: a byte strobe follows a falling edge
  p_byte_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(fall_p));

  // R7: an error never coincides with a byte
  p_no_byte_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !byte_valid);

  // R8: a post-negotiation stop only after two silent periods
  p_stop_after_silence_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_stop && $past(st) != ST_NEGO) |->
      (33'($past(since_rise)) >= {$past(ref_per), 1'b0}));

  // R9: the short-byte flag only comes with a stop
  p_short_with_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    short_byte |-> msg_stop);

  // R10: a stop out of negotiation only after the timeout
  p_nego_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_stop && $past(st) == ST_NEGO) |-> ($past(since_rise) >= NEGO_LIM));
endmodule

// File: rtl/pw_bit_receiver.sv
module pw_bit_receiver #(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_LEN  = 5,
  parameter int CNT_W       = 16,
  parameter int IDLE_MIN    = 16,
  parameter int NEGO_MAX    = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic       msg_start,
  output logic       msg_stop,
  output logic       frame_err,
  output logic       short_byte
);
  logic             line_s;
  logic             line_f;
  logic             rise_p;
  logic             fall_p;
  logic [CNT_W-1:0] low_run;
  logic [CNT_W-1:0] since_rise;

  line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(line_in), .d_out(line_s)
  );

  glitch_filter #(.HOLD(GLITCH_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .lvl_in(line_s), .lvl_out(line_f),
    .rise_p(rise_p), .fall_p(fall_p)
  );

  pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .lvl(line_f), .rise_p(rise_p),
    .low_run(low_run), .since_rise(since_rise)
  );

  frame_fsm #(.CNT_W(CNT_W), .IDLE_MIN(IDLE_MIN), .NEGO_MAX(NEGO_MAX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise_p(rise_p), .fall_p(fall_p),
    .low_run(low_run), .since_rise(since_rise),
    .byte_data(byte_data), .byte_valid(byte_valid), .msg_start(msg_start),
    .msg_stop(msg_stop), .frame_err(frame_err), .short_byte(short_byte)
  );
endmodule

// File: tb/pw_bit_receiver_tb_top.sv
module pw_bit_receiver_tb_top;
  localparam int SY   = 2;
  localparam int GL   = 5;
  localparam int CW   = 16;
  localparam int IMIN = 16;
  localparam int NMAX = 500;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0;
  logic [7:0] byte_data;
  logic byte_valid, msg_start, msg_stop, frame_err, short_byte;

  always #5 clk = ~clk;

  pw_bit_receiver #(.SYNC_STAGES(SY), .GLITCH_LEN(GL), .CNT_W(CW),
                    .IDLE_MIN(IMIN), .NEGO_MAX(NMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .byte_data(byte_data),
    .byte_valid(byte_valid), .msg_start(msg_start), .msg_stop(msg_stop),
    .frame_err(frame_err), .short_byte(short_byte)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic report(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_pipe[$];
  int m_lvl, m_diff, m_up, m_dn, m_low, m_since;
  int m_phase, m_per, m_cnt, m_acc;
  int m_bv, m_bd, m_ms, m_mp, m_fe, m_sb;

  task automatic model_reset();
    m_pipe = {};
    for (int i = 0; i < SY; i++) m_pipe.push_back(0);
    m_lvl = 0; m_diff = 0; m_up = 0; m_dn = 0; m_low = 0; m_since = 0;
    m_phase = 0; m_per = 0; m_cnt = 0; m_acc = 0;
    m_bv = 0; m_bd = 0; m_ms = 0; m_mp = 0; m_fe = 0; m_sb = 0;
  endtask

  task automatic model_step(input int raw);
    int hb, b, s;
    m_bv = 0; m_ms = 0; m_mp = 0; m_fe = 0; m_sb = 0;
    case (m_phase)
      0: if (m_up && m_low >= IMIN) begin m_phase = 1; m_ms = 1; end
      1: if (m_up) begin m_per = m_since; m_cnt = 0; m_acc = 0; m_phase = 2; end
         else if (m_since >= NMAX) begin m_mp = 1; m_phase = 0; end
      2: if (!m_up) begin
           if (m_since >= 2 * m_per) begin
             m_mp = 1; m_sb = (m_cnt != 0); m_phase = 0;
           end else if (m_dn) begin
             hb = 10 * m_since;
             if (hb >= 6 * m_per && hb <= 8 * m_per) b = 1;
             else if (hb >= 2 * m_per && hb <= 4 * m_per) b = 0;
             else b = -1;
             if (b < 0) begin m_fe = 1; m_phase = 3; end
             else begin
               m_acc = ((m_acc << 1) | b) & 255;
               m_cnt++;
               if (m_cnt == 8) begin m_bd = m_acc; m_bv = 1; m_cnt = 0; end
             end
           end
         end
      default: if (!m_up && m_since >= 2 * m_per) begin m_mp = 1; m_phase = 0; end
    endcase
    m_low   = m_lvl ? 0 : ((m_low < CMAX) ? m_low + 1 : CMAX);
    m_since = m_up ? 1 : ((m_since < CMAX) ? m_since + 1 : CMAX);
    s = m_pipe[SY-1];
    m_up = 0; m_dn = 0;
    if (s != m_lvl) begin
      if (m_diff == GL - 1) begin
        m_lvl = s; m_up = s; m_dn = !s; m_diff = 0;
      end else m_diff++;
    end else m_diff = 0;
    void'(m_pipe.pop_back());
    m_pipe.push_front(raw);
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step(int'(line_in));
  end

  // every-clock comparison and event tallies
  int n_start = 0, n_stop = 0, n_err = 0, n_short = 0;
  int got[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (msg_start !== m_ms[0]) begin fails++; $display("FAIL R2 msg_start: got %0b expected %0d", msg_start, m_ms); end
      if (byte_valid !== m_bv[0]) begin fails++; $display("FAIL R6 byte_valid: got %0b expected %0d", byte_valid, m_bv); end
      if (byte_data !== m_bd[7:0]) begin fails++; $display("FAIL R6 byte_data: got %0h expected %0h", byte_data, m_bd); end
      if (frame_err !== m_fe[0]) begin fails++; $display("FAIL R7 frame_err: got %0b expected %0d", frame_err, m_fe); end
      if (msg_stop !== m_mp[0]) begin fails++; $display("FAIL R8 msg_stop: got %0b expected %0d", msg_stop, m_mp); end
      if (short_byte !== m_sb[0]) begin fails++; $display("FAIL R9 short_byte: got %0b expected %0d", short_byte, m_sb); end
      if (byte_valid) got.push_back(int'(byte_data));
      n_start += int'(msg_start);
      n_stop  += int'(msg_stop);
      n_err   += int'(frame_err);
      n_short += int'(short_byte);
    end
  end

  // ---------------- stimulus helpers ----------------
  int highs[$];
  int b_start, b_stop, b_err, b_short;

  task automatic hold(input logic v, input int n);
    line_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic snap();
    b_start = n_start; b_stop = n_stop; b_err = n_err; b_short = n_short;
    got = {};
  endtask

  task automatic add_byte(input int val, input int per);
    for (int i = 7; i >= 0; i--) highs.push_back(((val >> i) & 1) ? per * 3 / 4 : per * 3 / 10);
  endtask

  task automatic send_msg(input int per);
    hold(1'b1, per / 2);
    hold(1'b0, per - per / 2);
    while (highs.size() > 0) begin
      int h;
      h = highs.pop_front();
      hold(1'b1, h);
      hold(1'b0, per - h);
    end
    hold(1'b0, 3 * per + 40);
  endtask

  task automatic tally(input string req, input int starts, input int stops,
                       input int errs, input int shorts, input int nbytes);
    report(req, "starts", n_start - b_start, starts);
    report(req, "stops", n_stop - b_stop, stops);
    report("R7", "errors", n_err - b_err, errs);
    report("R9", "short flags", n_short - b_short, shorts);
    report("R6", "byte count", got.size(), nbytes);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    report("R11", "byte_data", int'(byte_data), 0);
    report("R11", "byte_valid", int'(byte_valid), 0);
    report("R11", "msg_start", int'(msg_start), 0);
    report("R11", "msg_stop", int'(msg_stop), 0);
    report("R11", "frame_err", int'(frame_err), 0);
    report("R11", "short_byte", int'(short_byte), 0);
    rst_n = 1'b1;

    // R2: rising edges after short low runs open nothing
    snap();
    hold(1'b1, 50); hold(1'b0, 10); hold(1'b1, 10); hold(1'b0, 40);
    report("R2", "starts after short idle", n_start - b_start, 0);

    // R3/R4/R5/R6: two bytes at T=50
    snap();
    add_byte(8'hA5, 50); add_byte(8'h3C, 50);
    send_msg(50);
    tally("R3", 1, 1, 0, 0, 2);
    if (got.size() == 2) begin
      report("R6", "first byte", got[0], 8'hA5);
      report("R6", "second byte", got[1], 8'h3C);
    end

    // R3: different negotiated period T=60
    snap();
    add_byte(8'hF0, 60);
    send_msg(60);
    tally("R3", 1, 1, 0, 0, 1);
    if (got.size() == 1) report("R3", "byte at T=60", got[0], 8'hF0);

    // R4/R5 window bounds at T=50: 30,40 -> 1 ; 10,20 -> 0
    snap();
    highs = {30, 40, 10, 20, 30, 10, 40, 20};
    send_msg(50);
    tally("R4", 1, 1, 0, 0, 1);
    if (got.size() == 1) report("R5", "boundary byte", got[0], 8'hCA);

    // R5: high time just under the 0 window
    snap();
    highs = {9};
    send_msg(50);
    tally("R7", 1, 1, 1, 0, 0);

    // R4: high time just over the 1 window
    snap();
    highs = {41};
    send_msg(50);
    tally("R7", 1, 1, 1, 0, 0);

    // R7: error mid-message, then a full byte that must be discarded
    snap();
    highs = {37, 15, 25};
    add_byte(8'hFF, 50);
    send_msg(50);
    tally("R7", 1, 1, 1, 0, 0);

    // R9: stop with three bits pending
    snap();
    add_byte(8'h81, 50);
    highs.push_back(37); highs.push_back(15); highs.push_back(37);
    send_msg(50);
    tally("R9", 1, 1, 0, 1, 1);
    if (got.size() == 1) report("R9", "full byte before partial", got[0], 8'h81);

    // R1: spike one clock shorter than the filter is ignored
    snap();
    hold(1'b1, GL - 1); hold(1'b0, 100);
    report("R1", "starts after short spike", n_start - b_start, 0);
    report("R1", "stops after short spike", n_stop - b_stop, 0);

    // R1/R10: pulse of exactly the filter length starts; negotiation times out
    snap();
    hold(1'b1, GL); hold(1'b0, NMAX + 100);
    tally("R10", 1, 1, 0, 0, 0);

    // R8: receiver is back in idle and takes a fresh message
    snap();
    add_byte(8'h5A, 50);
    send_msg(50);
    tally("R8", 1, 1, 0, 0, 1);
    if (got.size() == 1) report("R8", "byte after recovery", got[0], 8'h5A);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule